// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single memory access requests into bus cycles on a bus whose low address byte and data byte share one set of bidirectional lines. A requester presents a 16-bit address, a direction bit and, for stores, a data byte. Once the sequencer is idle, it takes the request and steps through a fixed series of clock-long T-states. It drives the high address byte and the shared lines, a latch-enable pulse that an external latch uses to capture the low address byte, a select line that marks memory cycles, and active-low read and write strobes.

In the first T-state the full address is on the bus and the latch enable is high. After that the shared lines either carry the store data or are released so that memory can drive them. A load samples the shared lines on the clock edge that ends its last T-state. When each cycle finishes, a one-clock completion pulse is raised, and for a load the captured byte is shown alongside that pulse. Loads take three T-states and stores take four, because a store has a final state that ends the write strobe before the lines are released.

Top module: `mbus_seq`

## Requirements
- R1: After reset the sequencer is idle: `reqReady`=1, `ale`=0, `rdN`=1, `wrN`=1, `adOe`=0, `ioMemN`=1, `done`=0.
- R2: In the first T-state (the clock after a request is accepted), `ale`=1, `addrHi` equals address bits 15:8, `adOut` equals address bits 7:0, `adOe`=1, and both strobes are high.
- R3: `ale` is high only in the first T-state, for exactly one clock. Whenever `ale` is high, the shared lines are driven and neither strobe is active.
- R4: A load drives `rdN` low in T-states two and three only. `adOe` is 0 in those states.
- R5: A load captures `adIn` on the clock edge that ends T-state three and shows it on `rdData` in the following clock.
- R6: A store keeps `wrN` high in T-state one and low in T-states two and three. It drives `adOut` with the store data and `adOe`=1 from T-state two through T-state four.
- R7: A store raises `wrN` again in T-state four. In the clock after that, `adOe` is 0.
- R8: `done` is high for exactly one clock, the one after the final T-state. `reqReady` is high only while idle, and a request presented in the `done` clock is accepted there.
- R9: A request presented while a cycle is in progress is ignored. The running cycle's address and direction are not changed by it.
- R10: `rdN` and `wrN` are never low together.
- R11: `ioMemN` is 0 in every T-state of a cycle and 1 while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Store data |
| reqReady | output | 1 | Sequencer idle, request taken this clock if valid |
| addrHi | output | 8 | High address byte |
| adOut | output | 8 | Shared lines, outgoing value |
| adOe | output | 1 | Output enable for the shared lines |
| adIn | input | 8 | Shared lines, incoming value |
| ale | output | 1 | Address latch enable |
| ioMemN | output | 1 | 0 during memory cycles |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| rdData | output | 8 | Captured load data |
| done | output | 1 | One-clock cycle completion pulse |

## Verification
The completion pulse of one cycle and the acceptance of the next request can fall in the same clock, because the sequencer is idle again exactly when `done` is high. The bench finishes a load and presents a store in its `done` clock. It then checks that the load data is still shown in that clock and that the store's first T-state, with `ale` high, follows at once with no idle gap. A second scenario keeps a conflicting request asserted through a busy cycle, to show that nothing is taken until the sequencer is idle again.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } tState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic driveAddr;
    logic driveData;
    logic ale;
    logic rd;
    logic wr;
    logic memCyc;
  } busCtl_t;
endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    done,
  output busCtl_t ctl
);
  tState_e stQ, stD;
  logic    isWriteQ;
  logic    doneQ;

  always_comb begin
    ctl = '0;
    stD = stQ;
    unique case (stQ)
      ST_IDLE: begin
        ctl.load = reqValid;
        if (reqValid) stD = ST_T1;
      end
      ST_T1: begin
        ctl.memCyc    = 1'b1;
        ctl.driveAddr = 1'b1;
        ctl.ale       = 1'b1;
        stD           = ST_T2;
      end
      ST_T2: begin
        ctl.memCyc    = 1'b1;
        ctl.wr        = isWriteQ;
        ctl.driveData = isWriteQ;
        ctl.rd        = !isWriteQ;
        stD           = ST_T3;
      end
      ST_T3: begin
        ctl.memCyc    = 1'b1;
        ctl.wr        = isWriteQ;
        ctl.driveData = isWriteQ;
        ctl.rd        = !isWriteQ;
        ctl.capture   = !isWriteQ;
        stD           = isWriteQ ? ST_T4 : ST_IDLE;
      end
      ST_T4: begin
        ctl.memCyc    = 1'b1;
        ctl.driveData = 1'b1;
        stD           = ST_IDLE;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      isWriteQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stQ <= stD;
      if (ctl.load) isWriteQ <= reqWrite;
      doneQ <= (stQ == ST_T4) || (stQ == ST_T3 && !isWriteQ);
    end
  end

  assign reqReady = (stQ == ST_IDLE);
  assign done     = doneQ;
endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              ale,
  output logic              ioMemN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] rdData
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdDataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdDataQ <= adIn;
    end
  end

  assign addrHi = addrQ[ADDR_W-1 -: HI_W];
  assign adOut  = ctl.driveAddr ? addrQ[DATA_W-1:0] : wdataQ;
  assign adOe   = ctl.driveAddr | ctl.driveData;
  assign ale    = ctl.ale;
  assign ioMemN = !ctl.memCyc;
  assign rdN    = !ctl.rd;
  assign wrN    = !ctl.wr;
  assign rdData = rdDataQ;
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     reqReady,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     ioMemN,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done
);
  busCtl_t ctl;

  mbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .done(done), .ctl(ctl)
  );

  mbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .adIn(adIn), .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .ale(ale),
    .ioMemN(ioMemN), .rdN(rdN), .wrN(wrN), .rdData(rdData)
  );
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqReady,
  input logic [HI_W-1:0] addrHi,
  input logic            adOe,
  input logic            ale,
  input logic            ioMemN,
  input logic            rdN,
  input logic            wrN,
  input logic            done
);
  p_ale_drives_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (adOe && rdN && wrN));
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_strobe_follows_ale_r6: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (!rdN || !wrN));
  p_read_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (rdN && wrN && !ale && ioMemN));
  p_busy_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(addrHi));
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_mem_select_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN || ale) |-> !ioMemN);
endmodule

bind mbus_seq mbus_seq_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .addrHi(addrHi), .adOe(adOe),
  .ale(ale), .ioMemN(ioMemN), .rdN(rdN), .wrN(wrN), .done(done)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  adIn = '0;
  logic        reqReady, adOe, ale, ioMemN, rdN, wrN, done;
  logic [7:0]  addrHi, adOut, rdData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  mbus_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .adIn(adIn), .ale(ale),
    .ioMemN(ioMemN), .rdN(rdN), .wrN(wrN), .rdData(rdData), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic tReset();
    check("R1 reqReady", reqReady, 1);
    check("R1 ale", ale, 0);
    check("R1 rdN", rdN, 1);
    check("R1 wrN", wrN, 1);
    check("R1 adOe", adOe, 0);
    check("R1 ioMemN", ioMemN, 1);
    check("R1 done", done, 0);
  endtask

  // issue a request at a negedge; returns at the negedge inside T1
  task automatic issue(input logic wr, input logic [15:0] a, input logic [7:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkT1(input logic [15:0] a);
    check("R2 ale", ale, 1);
    check("R2 addrHi", addrHi, a[15:8]);
    check("R2 adOut", adOut, a[7:0]);
    check("R2 adOe", adOe, 1);
    check("R2 strobes", {rdN, wrN}, 2'b11);
    check("R11 ioMemN T1", ioMemN, 0);
    check("R8 busy", reqReady, 0);
  endtask

  // from T1 negedge through the read; returns at the done negedge
  task automatic readBody(input logic [15:0] a, input logic [7:0] mem);
    checkT1(a);
    adIn = mem;
    @(negedge clk);
    check("R3 ale low T2", ale, 0);
    check("R4 rdN T2", rdN, 0);
    check("R4 adOe T2", adOe, 0);
    check("R10 wrN T2", wrN, 1);
    @(negedge clk);
    check("R4 rdN T3", rdN, 0);
    check("R4 adOe T3", adOe, 0);
    check("R11 ioMemN T3", ioMemN, 0);
    check("R8 no early done", done, 0);
    @(negedge clk);
    adIn = ~mem;
    check("R8 done", done, 1);
    check("R5 rdData", rdData, mem);
    check("R4 rdN released", rdN, 1);
    check("R8 ready", reqReady, 1);
    check("R11 ioMemN idle", ioMemN, 1);
  endtask

  task automatic tRead(input logic [15:0] a, input logic [7:0] mem);
    issue(1'b0, a, 8'h00);
    readBody(a, mem);
    @(negedge clk);
    check("R8 done one clock", done, 0);
    check("R5 rdData held", rdData, mem);
  endtask

  task automatic tWrite(input logic [15:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    checkT1(a);
    @(negedge clk);
    check("R6 wrN T2", wrN, 0);
    check("R6 adOut T2", adOut, d);
    check("R6 adOe T2", adOe, 1);
    check("R10 rdN T2", rdN, 1);
    check("R3 ale low", ale, 0);
    @(negedge clk);
    check("R6 wrN T3", wrN, 0);
    check("R6 adOut T3", adOut, d);
    @(negedge clk);
    check("R7 wrN T4", wrN, 1);
    check("R6 adOut T4", adOut, d);
    check("R6 adOe T4", adOe, 1);
    check("R11 ioMemN T4", ioMemN, 0);
    check("R8 no done T4", done, 0);
    @(negedge clk);
    check("R8 done", done, 1);
    check("R7 released", adOe, 0);
    check("R7 wrN idle", wrN, 1);
    @(negedge clk);
    check("R8 done one clock", done, 0);
  endtask

  task automatic tBusyIgnore();
    issue(1'b0, 16'h12A5, 8'h00);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'hEE11; reqWdata = 8'h77;
    checkT1(16'h12A5);
    adIn = 8'h3C;
    @(negedge clk);
    check("R9 still read", {rdN, wrN}, 2'b01);
    check("R9 addrHi kept", addrHi, 8'h12);
    check("R9 not ready", reqReady, 0);
    reqValid = 1'b0;
    @(negedge clk);
    check("R9 still read T3", {rdN, wrN}, 2'b01);
    @(negedge clk);
    check("R9 done", done, 1);
    check("R9 rdData", rdData, 8'h3C);
    @(negedge clk);
    check("R9 no restart", ale, 0);
    check("R9 idle", reqReady, 1);
  endtask

  task automatic tBackToBack();
    issue(1'b0, 16'h4081, 8'h00);
    readBody(16'h4081, 8'h96);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h9F02; reqWdata = 8'h5A;
    @(negedge clk);
    reqValid = 1'b0;
    check("R8 accept on done", ale, 1);
    check("R8 done dropped", done, 0);
    check("R2 next addrHi", addrHi, 8'h9F);
    check("R2 next adOut", adOut, 8'h02);
    @(negedge clk);
    check("R6 next wrN", wrN, 0);
    check("R6 next data", adOut, 8'h5A);
    repeat (3) @(negedge clk);
    check("R8 back idle", reqReady, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRead(16'hA55A, 8'hC3);
    tRead(16'h00FF, 8'h00);
    tWrite(16'h1234, 8'hE7);
    tWrite(16'hFFFF, 8'hFF);
    tBusyIgnore();
    tBackToBack();
    finishRun();
  end
endmodule